// File: doc/BRIEF.md
# Hotplug event register block

This block holds a small general-purpose event register pair for slot hotplug signalling. The host reaches it one byte at a time through a four-byte window. The window holds a 16-bit status register and a 16-bit enable register. Each register is split into a low byte lane and a high byte lane. Status bits can only be cleared by the host, using write-one-to-clear. Enable bits are plain read/write.

Slot logic reports insert and remove events, each with a slot number. Either event sets the hotplug status bit. An insert also records the slot in a sticky "inserted" bitmap, and a remove records it in a sticky "removed" bitmap. A level event output is high while the hotplug status bit and its enable bit are both set.

A separate eject command carries a 32-bit value. The lowest set bit of that value names the target slot. If the slot may be ejected, the block sends a one-cycle pulse and the slot number to the surrounding logic.

Top module: `hpev_block`

## Requirements
- R1: Reset clears status, enable and both bitmaps. After reset the event output is low, no eject pulse is present, and every byte in the window reads 0x00.
- R2: Reads return data combinationally. Offset 0 returns status bits 7:0, offset 1 status bits 15:8, offset 2 enable bits 7:0 and offset 3 enable bits 15:8. Offset bit 1 selects enable over status, and offset bit 0 selects the high lane.
- R3: A byte write to offset 0 or 1 clears each status bit of that lane where the data bit is 1. The other lane is not changed.
- R4: A byte write to offset 2 or 3 replaces that lane of the enable register. The other lane is not changed.
- R5: An insert event with slot number s sets status bit 1 and bit s of the inserted bitmap, from the next clock edge on.
- R6: A remove event with slot number s sets status bit 1 and bit s of the removed bitmap, from the next clock edge on.
- R7: If a hotplug event and a status write that clears bit 1 land in the same cycle, bit 1 ends up set.
- R8: The event output is high exactly when status bit 1 and enable bit 1 are both set.
- R9: One cycle after an eject write, a one-cycle pulse is given with the slot number of the lowest set bit of the written value.
- R10: An eject write of zero gives no pulse. An eject write whose lowest set bit names a slot marked fixed also gives no pulse. Higher bits are not tried in its place.
- R11: Offsets 4 to 7 read 0x00, and writes to them change nothing.
- R12: Bitmap bits stay set until reset. A repeated event for a slot leaves the other bits as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Byte access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data (combinational) |
| ins_v | input | 1 | Insert event strobe |
| ins_slot | input | SLOT_W | Inserted slot number |
| rem_v | input | 1 | Remove event strobe |
| rem_slot | input | SLOT_W | Removed slot number |
| ej_we | input | 1 | Eject command write strobe |
| ej_wdata | input | SLOTS | Eject command value |
| slot_fixed | input | SLOTS | Per-slot flag: slot may not be ejected |
| up_map | output | SLOTS | Inserted-slot bitmap |
| down_map | output | SLOTS | Removed-slot bitmap |
| evt_o | output | 1 | Level event output |
| ej_pulse | output | 1 | One-cycle eject pulse |
| ej_slot | output | SLOT_W | Slot number of the last accepted eject |

## Verification
Two actions can meet in the same clock edge: a hotplug event setting status bit 1, and the host clearing that bit with a write-one-to-clear. The bench provokes this by driving an insert strobe and a write of 0x02 to offset 0 in the same cycle. It then judges the result through the normal read path and the event output. Status must read 0x02, the event output must stay high, and the inserted bitmap must gain the new slot while keeping the slots it already had.

// File: rtl/hpev_pkg.sv
package hpev_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned LANES   = REG_W / BYTE_W;
  localparam int unsigned WIN_LEN = 2 * LANES;

  // Clear the bits of a lane where the written data holds ones.
  function automatic logic [BYTE_W-1:0] lane_w1c(input logic [BYTE_W-1:0] cur,
                                                 input logic [BYTE_W-1:0] wd);
    return cur & ~wd;
  endfunction

  // Select one byte lane of a register.
  function automatic logic [BYTE_W-1:0] lane_pick(input logic [REG_W-1:0] r,
                                                  input logic hi);
    return hi ? r[REG_W-1:BYTE_W] : r[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/hpev_regs.sv
module hpev_regs
  import hpev_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int HP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BYTE_W-1:0] acc_wdata,
  input  logic              hp_set,
  output logic [REG_W-1:0]  sts_q,
  output logic [REG_W-1:0]  en_q,
  output logic [BYTE_W-1:0] rd_data
);
  logic             in_win;
  logic             sel_en;
  logic             wr_ok;
  logic [LANES-1:0] lane_hit;
  logic [REG_W-1:0] sts_after;
  logic [REG_W-1:0] sts_d;
  logic [REG_W-1:0] en_d;

  assign in_win = (acc_addr >> 2) == '0;
  assign sel_en = acc_addr[1];
  assign wr_ok  = acc_en && acc_wr && in_win;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_hit[l] = wr_ok && (acc_addr[0] == 1'(l));
    assign sts_after[l*BYTE_W +: BYTE_W] = (lane_hit[l] && !sel_en)
        ? lane_w1c(sts_q[l*BYTE_W +: BYTE_W], acc_wdata)
        : sts_q[l*BYTE_W +: BYTE_W];
    assign en_d[l*BYTE_W +: BYTE_W] = (lane_hit[l] && sel_en)
        ? acc_wdata
        : en_q[l*BYTE_W +: BYTE_W];
  end

  // a hardware set beats a host clear landing in the same cycle
  assign sts_d = sts_after | (REG_W'(hp_set) << HP_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (acc_en && !acc_wr && in_win)
      rd_data = lane_pick(sel_en ? en_q : sts_q, acc_addr[0]);
  end
endmodule

// File: rtl/hpev_slot_maps.sv
module hpev_slot_maps #(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_v,
  input  logic [SLOT_W-1:0] ins_slot,
  input  logic              rem_v,
  input  logic [SLOT_W-1:0] rem_slot,
  output logic [SLOTS-1:0]  up_q,
  output logic [SLOTS-1:0]  down_q,
  output logic              hp_set
);
  function automatic logic [SLOTS-1:0] slot_bit(input logic v, input logic [SLOT_W-1:0] s);
    return v ? (SLOTS'(1) << s) : '0;
  endfunction

  assign hp_set = ins_v || rem_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q   <= '0;
      down_q <= '0;
    end else begin
      up_q   <= up_q   | slot_bit(ins_v, ins_slot);
      down_q <= down_q | slot_bit(rem_v, rem_slot);
    end
  end
endmodule

// File: rtl/hpev_eject_dec.sv
module hpev_eject_dec #(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ej_we,
  input  logic [SLOTS-1:0]  ej_wdata,
  input  logic [SLOTS-1:0]  slot_fixed,
  output logic              ej_pulse,
  output logic [SLOT_W-1:0] ej_slot
);
  // Index of the lowest set bit; the downward scan leaves the lowest one last.
  function automatic logic [SLOT_W-1:0] low_idx(input logic [SLOTS-1:0] v);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (v[i]) r = SLOT_W'(i);
    return r;
  endfunction

  logic [SLOT_W-1:0] tgt;
  logic              any_bit;
  logic              fire;

  assign tgt     = low_idx(ej_wdata);
  assign any_bit = |ej_wdata;
  assign fire    = ej_we && any_bit && !slot_fixed[tgt];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ej_pulse <= 1'b0;
      ej_slot  <= '0;
    end else begin
      ej_pulse <= fire;
      if (fire) ej_slot <= tgt;
    end
  end
endmodule

// File: rtl/hpev_block.sv
module hpev_block
  import hpev_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int ADDR_W = 3,
  parameter int HP_BIT = 1,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  input  logic              ins_v,
  input  logic [SLOT_W-1:0] ins_slot,
  input  logic              rem_v,
  input  logic [SLOT_W-1:0] rem_slot,
  input  logic              ej_we,
  input  logic [SLOTS-1:0]  ej_wdata,
  input  logic [SLOTS-1:0]  slot_fixed,
  output logic [SLOTS-1:0]  up_map,
  output logic [SLOTS-1:0]  down_map,
  output logic              evt_o,
  output logic              ej_pulse,
  output logic [SLOT_W-1:0] ej_slot
);
  // named internal events for the checker
  logic             hp_set;
  logic [REG_W-1:0] sts_q;
  logic [REG_W-1:0] en_q;

  hpev_slot_maps #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_maps (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_v    (ins_v),
    .ins_slot (ins_slot),
    .rem_v    (rem_v),
    .rem_slot (rem_slot),
    .up_q     (up_map),
    .down_q   (down_map),
    .hp_set   (hp_set)
  );

  hpev_regs #(.ADDR_W(ADDR_W), .HP_BIT(HP_BIT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .hp_set    (hp_set),
    .sts_q     (sts_q),
    .en_q      (en_q),
    .rd_data   (acc_rdata)
  );

  hpev_eject_dec #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_eject (
    .clk        (clk),
    .rst_n      (rst_n),
    .ej_we      (ej_we),
    .ej_wdata   (ej_wdata),
    .slot_fixed (slot_fixed),
    .ej_pulse   (ej_pulse),
    .ej_slot    (ej_slot)
  );

  assign evt_o = sts_q[HP_BIT] && en_q[HP_BIT];
endmodule

// File: rtl/hpev_checker.sv
module hpev_checker #(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = 5,
  parameter int ADDR_W = 3,
  parameter int HP_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [7:0]        acc_wdata,
  input logic [7:0]        acc_rdata,
  input logic              ins_v,
  input logic [SLOT_W-1:0] ins_slot,
  input logic              rem_v,
  input logic [SLOT_W-1:0] rem_slot,
  input logic              ej_we,
  input logic [SLOTS-1:0]  ej_wdata,
  input logic [SLOTS-1:0]  slot_fixed,
  input logic [SLOTS-1:0]  up_map,
  input logic [SLOTS-1:0]  down_map,
  input logic              evt_o,
  input logic              ej_pulse,
  input logic [SLOT_W-1:0] ej_slot,
  input logic              hp_set,
  input logic [15:0]       sts_q,
  input logic [15:0]       en_q
);
  AST_HP_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    hp_set |=> sts_q[HP_BIT]); // R7
  AST_INS_MARKS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ins_v |=> ((up_map >> $past(ins_slot)) & SLOTS'(1)) != '0); // R5
  AST_REM_MARKS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    rem_v |=> ((down_map >> $past(rem_slot)) & SLOTS'(1)) != '0); // R6
  AST_MAPS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((up_map & $past(up_map)) == $past(up_map)) &&
             ((down_map & $past(down_map)) == $past(down_map))); // R12
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_addr == '0 && acc_wdata[HP_BIT] && !hp_set)
      |=> !sts_q[HP_BIT]); // R3
  AST_EVT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_o) |-> ($past(hp_set) || $past(acc_en && acc_wr))); // R8
  AST_EJECT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ej_pulse |-> $past(ej_we) &&
                 ((($past(ej_wdata) >> ej_slot) & SLOTS'(1)) != '0) &&
                 ((($past(slot_fixed) >> ej_slot) & SLOTS'(1)) == '0)); // R9
  AST_EJECT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    ej_pulse |-> (($past(ej_wdata) & ((SLOTS'(1) << ej_slot) - SLOTS'(1))) == '0)); // R9
  AST_EJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ej_we && ej_wdata == '0) |=> !ej_pulse); // R10
  AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_addr >= ADDR_W'(4)) |-> acc_rdata == 8'h00); // R11
endmodule

bind hpev_block hpev_checker #(
  .SLOTS(SLOTS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .HP_BIT(HP_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
  .ins_v(ins_v), .ins_slot(ins_slot), .rem_v(rem_v), .rem_slot(rem_slot),
  .ej_we(ej_we), .ej_wdata(ej_wdata), .slot_fixed(slot_fixed),
  .up_map(up_map), .down_map(down_map), .evt_o(evt_o),
  .ej_pulse(ej_pulse), .ej_slot(ej_slot),
  .hp_set(hp_set), .sts_q(sts_q), .en_q(en_q)
);

// File: tb/hpev_block_bench.sv
module hpev_block_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 12;
  // row: {write, addr[2:0], data[7:0], expected read[7:0]}
  localparam logic [19:0] VEC [NV] = '{
    20'hAA500, 20'h200A5, 20'hB3C00, 20'h3003C, 20'h200A5, 20'hA0200,
    20'h20002, 20'h3003C, 20'hEFF00, 20'h60000, 20'h20002, 20'h00000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0, acc_wr = 1'b0;
  logic [2:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0, acc_rdata;
  logic ins_v = 1'b0, rem_v = 1'b0;
  logic [4:0] ins_slot = '0, rem_slot = '0;
  logic ej_we = 1'b0;
  logic [31:0] ej_wdata = '0, slot_fixed = '0;
  logic [31:0] up_map, down_map;
  logic evt_o, ej_pulse;
  logic [4:0] ej_slot;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hpev_block u_hpev_block (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .ins_v(ins_v), .ins_slot(ins_slot), .rem_v(rem_v), .rem_slot(rem_slot),
    .ej_we(ej_we), .ej_wdata(ej_wdata), .slot_fixed(slot_fixed),
    .up_map(up_map), .down_map(down_map), .evt_o(evt_o),
    .ej_pulse(ej_pulse), .ej_slot(ej_slot)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_b(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk); acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd_b(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); acc_en = 1; acc_wr = 0; acc_addr = a;
    #1 d = acc_rdata;
    acc_en = 0;
  endtask

  task automatic ins(input logic [4:0] s);
    @(negedge clk); ins_v = 1; ins_slot = s;
    @(negedge clk); ins_v = 0;
  endtask

  task automatic rem(input logic [4:0] s);
    @(negedge clk); rem_v = 1; rem_slot = s;
    @(negedge clk); rem_v = 0;
  endtask

  task automatic eject(input logic [31:0] v, output logic p, output logic [4:0] s);
    @(negedge clk); ej_we = 1; ej_wdata = v;
    @(negedge clk); ej_we = 0; p = ej_pulse; s = ej_slot;
  endtask

  function automatic logic [4:0] first_one(input logic [31:0] v);
    logic [4:0] r = '0;
    bit seen = 0;
    for (int i = 0; i < 32; i++)
      if (v[i] && !seen) begin r = 5'(i); seen = 1; end
    return r;
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic p;
    logic [4:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1", "up_map", up_map, 0);
    check("R1", "down_map", down_map, 0);
    check("R1", "evt_o", 32'(evt_o), 0);
    check("R1", "ej_pulse", 32'(ej_pulse), 0);
    rd_b(3'd3, rd); check("R1", "enable hi", 32'(rd), 0);

    // table: byte lanes, enable replace, out-of-window (R2 R4 R11)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) wr_b(VEC[i][18:16], VEC[i][15:8]);
      else begin
        rd_b(VEC[i][18:16], rd);
        check("R2 R4 R11", $sformatf("table row %0d", i), 32'(rd), 32'(VEC[i][7:0]));
      end
    end

    // enable is now 0x3C02; hotplug bit enabled
    ins(5'd5);
    check("R5", "up_map after insert", up_map, 32'h20);
    rd_b(3'd0, rd); check("R5", "status lo", 32'(rd), 32'h02);
    check("R8", "evt_o set", 32'(evt_o), 1);

    rem(5'd31);
    check("R6", "down_map after remove", down_map, 32'h8000_0000);
    rd_b(3'd0, rd); check("R6", "status lo", 32'(rd), 32'h02);
    check("R12", "up_map kept", up_map, 32'h20);

    wr_b(3'd1, 8'hFF);
    rd_b(3'd0, rd); check("R3", "hi-lane clear leaves lo", 32'(rd), 32'h02);
    wr_b(3'd0, 8'h02);
    rd_b(3'd0, rd); check("R3", "lo-lane cleared", 32'(rd), 0);
    check("R8", "evt_o after clear", 32'(evt_o), 0);

    // same cycle: clear and insert (R7)
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = 3'd0; acc_wdata = 8'h02;
    ins_v = 1; ins_slot = 5'd0;
    @(negedge clk);
    acc_en = 0; acc_wr = 0; ins_v = 0;
    rd_b(3'd0, rd); check("R7", "set wins over clear", 32'(rd), 32'h02);
    check("R7", "evt_o stays", 32'(evt_o), 1);
    check("R12", "up_map accumulates", up_map, 32'h21);

    wr_b(3'd2, 8'h00);
    check("R8", "evt_o enable off", 32'(evt_o), 0);

    // eject (R9 R10)
    eject(32'h50, p, s);
    check("R9", "pulse", 32'(p), 1);
    check("R9", "slot", 32'(s), 32'(first_one(32'h50)));
    @(negedge clk); check("R9", "pulse one cycle", 32'(ej_pulse), 0);
    eject(32'h0, p, s);
    check("R10", "zero eject", 32'(p), 0);
    slot_fixed = 32'h08;
    eject(32'h18, p, s);
    check("R10", "fixed lowest slot", 32'(p), 0);
    check("R10", "slot held", 32'(s), 4);
    eject(32'h8000_0000, p, s);
    check("R9", "top slot pulse", 32'(p), 1);
    check("R9", "top slot", 32'(s), 32'(first_one(32'h8000_0000)));

    ins(5'd5);
    check("R12", "repeat insert", up_map, 32'h21);

    // mid-run reset (R1)
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    check("R1", "up_map after reset", up_map, 0);
    check("R1", "down_map after reset", down_map, 0);
    check("R1", "evt_o after reset", 32'(evt_o), 0);
    rd_b(3'd0, rd); check("R1", "status after reset", 32'(rd), 0);
    rd_b(3'd3, rd); check("R1", "enable hi after reset", 32'(rd), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule